// File: doc/BRIEF.md
# Compare match timer channel

One timer channel with a small word-addressed register set: a control/status word, an up-counter and a compare value. The counter advances on a tick taken from a slow reference clock, which reaches the block as a one-cycle strobe `ref_tick` in the bus clock domain and passes through a selectable divider. When the counter equals the compare value on a tick, the channel latches a match flag. In periodic mode it then restarts from zero; otherwise it keeps counting. If the match is routed to the interrupt line and enabled, it raises `irq`. A separate overflow flag records a wrap from all-ones to zero that came without a match.

Counting happens only while the external start input `run` is high. A bus write to the counter is not applied at once. It is staged and lands in the counting logic at the second reference strobe after the write, the way a counter kept in a slow clock domain behaves. Two control-word layouts are available through a parameter: a wide one with overflow flag, periodic select and request routing, and a narrow one that is always periodic.

Top module: `cmt_channel`

## Requirements
- R1: Word address 0 holds the control/status word, 1 the counter and 2 the compare value. After reset the counter reads 0, the compare value reads all-ones and the control word reads 0.
- R2: In the wide layout, clock-select bits 2:0 make one count take this many reference strobes: code 7 one, code 4 eight, code 5 thirty-two, code 6 one hundred twenty-eight. Codes 0 to 3 hold the counter.
- R3: In the narrow layout, bit 7 is the match flag, bit 6 the interrupt enable and bits 1:0 select 8, 32, 128 or 512 strobes per count for codes 0 to 3. The channel is always periodic, and bit 14 is not stored and reads 0.
- R4: On a tick where the counter equals the compare value, the match flag (bit 15 in the wide layout) sets. With bit 8 set, the counter returns to 0, so one period is the compare value plus one tick.
- R5: With bit 8 clear, the counter steps past the compare value to compare+1 after a match.
- R6: The overflow flag (bit 14) sets when the counter wraps from all-ones to 0 without a match. A wrap that is itself a match sets only the match flag.
- R7: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: In the wide layout, `irq` is the match flag AND enable bit 7 AND route field bits 5:4 equal to 2. Route values 0 and 1 keep `irq` low. In the narrow layout `irq` is the match flag AND bit 6.
- R9: A counter write takes effect at the second reference strobe after the write. Until then counter reads return the old count, which may still advance.
- R10: While `run` is low the counter holds and the divider is reset. Raising `run` resumes from the held value with a full divider interval.
- R11: A compare write takes effect on the next bus cycle and reads back at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| run | input | 1 | Start input; counting only while high |
| addr | input | 2 | Word address of the register access |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Match interrupt request |

## Verification
The divider is driven with every wide clock-select code and with two narrow codes. Reading the counter one strobe before and at the expected step tells each ratio apart from its neighbours and from an off-by-one divider. Match behaviour is compared between periodic and free-running mode, and between a plain wrap from all-ones and a wrap that coincides with the compare value. These cases separate the match, restart and overflow paths. A counter write is read back between its first and second strobe to show the staging delay. A clearing write that lands on a match cycle shows which of the two wins, and stopping and restarting `run` mid-interval shows that the divider is reset rather than paused.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
   localparam int DW    = 32;
   localparam int AW    = 2;
   localparam int DIV_W = 10;

   localparam logic [AW-1:0] A_CTRL = 2'd0;
   localparam logic [AW-1:0] A_CNT  = 2'd1;
   localparam logic [AW-1:0] A_CMP  = 2'd2;

   localparam logic [1:0] ROUTE_IRQ = 2'd2;

   function automatic logic [DIV_W-1:0] div_wide(input logic [2:0] sel);
      case (sel)
         3'd4:    div_wide = DIV_W'(8);
         3'd5:    div_wide = DIV_W'(32);
         3'd6:    div_wide = DIV_W'(128);
         3'd7:    div_wide = DIV_W'(1);
         default: div_wide = '0;
      endcase
   endfunction

   function automatic logic [DIV_W-1:0] div_narrow(input logic [2:0] sel);
      case (sel[1:0])
         2'd0:    div_narrow = DIV_W'(8);
         2'd1:    div_narrow = DIV_W'(32);
         2'd2:    div_narrow = DIV_W'(128);
         default: div_narrow = DIV_W'(512);
      endcase
   endfunction
endpackage

// File: rtl/cmt_prescale.sv
`timescale 1ns/1ps
module cmt_prescale #(
   parameter bit WIDE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);
   import cmt_pkg::*;

   logic [DIV_W-1:0] ratio;
   logic [DIV_W-1:0] pcnt;
   logic             at_end;

   generate
      if (WIDE) begin : g_wide
         assign ratio = div_wide(sel);
      end else begin : g_narrow
         assign ratio = div_narrow(sel);
      end
   endgenerate

   assign at_end = (ratio != '0) && (pcnt >= ratio - DIV_W'(1));
   assign tick   = run && ref_tick && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run || ratio == '0) begin
         pcnt <= '0;
      end else if (ref_tick) begin
         pcnt <= at_end ? '0 : DIV_W'(pcnt + 1'b1);
      end
   end
endmodule

// File: rtl/cmt_load_sync.sv
`timescale 1ns/1ps
module cmt_load_sync #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             wr,
   input  logic [CNT_W-1:0] wval,
   output logic             load_now,
   output logic [CNT_W-1:0] load_val
);
   localparam logic [1:0] STAGES = 2'd2;

   logic [1:0] left;

   assign load_now = ref_tick && (left == 2'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left     <= '0;
         load_val <= '0;
      end else if (wr) begin
         left     <= STAGES;
         load_val <= wval;
      end else if (ref_tick && left != '0) begin
         left     <= left - 2'd1;
      end
   end
endmodule

// File: rtl/cmt_count_core.sv
`timescale 1ns/1ps
module cmt_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_now,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             hit_match,
   output logic             hit_ovf
);
   logic eq;
   logic top;

   assign eq        = (count == cmp);
   assign top       = (count == '1);
   assign hit_match = tick && !load_now && eq;
   assign hit_ovf   = tick && !load_now && top && !eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load_now) begin
         count <= load_val;
      end else if (tick) begin
         if (eq && periodic) count <= '0;
         else                count <= CNT_W'(count + 1'b1);
      end
   end
endmodule

// File: rtl/cmt_ctrl_reg.sv
`timescale 1ns/1ps
module cmt_ctrl_reg #(
   parameter bit WIDE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [cmt_pkg::DW-1:0] wdata,
   input  logic                  set_match,
   input  logic                  set_ovf,
   output logic                  mflag,
   output logic                  oflag,
   output logic                  periodic,
   output logic [2:0]            sel,
   output logic                  irq,
   output logic [cmt_pkg::DW-1:0] rd_word
);
   import cmt_pkg::*;

   logic       ie;
   logic       unused_wdata;

   assign unused_wdata = ^wdata;

   generate
      if (WIDE) begin : g_wide
         logic [1:0] route;
         logic       per_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mflag <= 1'b0;
               oflag <= 1'b0;
               per_q <= 1'b0;
               ie    <= 1'b0;
               route <= '0;
               sel   <= '0;
            end else begin
               mflag <= (mflag && (!wr || wdata[15])) || set_match;
               oflag <= (oflag && (!wr || wdata[14])) || set_ovf;
               if (wr) begin
                  per_q <= wdata[8];
                  ie    <= wdata[7];
                  route <= wdata[5:4];
                  sel   <= wdata[2:0];
               end
            end
         end

         assign periodic = per_q;
         assign irq      = mflag && ie && (route == ROUTE_IRQ);
         assign rd_word  = {16'h0, mflag, oflag, 5'b0, per_q, ie, 1'b0,
                            route, 1'b0, sel};
      end else begin : g_narrow
         logic unused_ovf;

         assign unused_ovf = set_ovf;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mflag <= 1'b0;
               ie    <= 1'b0;
               sel   <= '0;
            end else begin
               mflag <= (mflag && (!wr || wdata[7])) || set_match;
               if (wr) begin
                  ie  <= wdata[6];
                  sel <= {1'b0, wdata[1:0]};
               end
            end
         end

         assign oflag    = 1'b0;
         assign periodic = 1'b1;
         assign irq      = mflag && ie;
         assign rd_word  = {24'h0, mflag, ie, 4'b0, sel[1:0]};
      end
   endgenerate
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel #(
   parameter int CNT_W = 32,
   parameter bit WIDE  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ref_tick,
   input  logic        run,
   input  logic [1:0]  addr,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq
);
   import cmt_pkg::*;

   generate
      if (CNT_W < 8 || CNT_W > DW) begin : g_bad_width
         $error("cmt_channel: CNT_W must lie between 8 and the bus width");
      end
   endgenerate

   logic             ctrl_wr;
   logic             cnt_wr;
   logic             cmp_wr;
   logic             cnt_tick;
   logic             load_now;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] cmp_q;
   logic             hit_match;
   logic             hit_ovf;
   logic             match_flag;
   logic             ovf_flag;
   logic             periodic;
   logic [2:0]       sel;
   logic [DW-1:0]    ctrl_word;

   assign ctrl_wr = wr_en && (addr == A_CTRL);
   assign cnt_wr  = wr_en && (addr == A_CNT);
   assign cmp_wr  = wr_en && (addr == A_CMP);

   always_ff @(posedge clk) begin
      if (!rst_n)      cmp_q <= '1;
      else if (cmp_wr) cmp_q <= wdata[CNT_W-1:0];
   end

   cmt_ctrl_reg #(.WIDE(WIDE)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctrl_wr),
      .wdata     (wdata),
      .set_match (hit_match),
      .set_ovf   (hit_ovf),
      .mflag     (match_flag),
      .oflag     (ovf_flag),
      .periodic  (periodic),
      .sel       (sel),
      .irq       (irq),
      .rd_word   (ctrl_word)
   );

   cmt_prescale #(.WIDE(WIDE)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .run      (run),
      .sel      (sel),
      .tick     (cnt_tick)
   );

   cmt_load_sync #(.CNT_W(CNT_W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .wr       (cnt_wr),
      .wval     (wdata[CNT_W-1:0]),
      .load_now (load_now),
      .load_val (load_val)
   );

   cmt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (cnt_tick),
      .load_now  (load_now),
      .load_val  (load_val),
      .cmp       (cmp_q),
      .periodic  (periodic),
      .count     (count_q),
      .hit_match (hit_match),
      .hit_ovf   (hit_ovf)
   );

   always_comb begin
      case (addr)
         A_CTRL:  rdata = ctrl_word;
         A_CNT:   rdata = DW'(count_q);
         A_CMP:   rdata = DW'(cmp_q);
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmt_channel_chk.sv
`timescale 1ns/1ps
module cmt_channel_chk #(
   parameter int CNT_W = 32,
   parameter bit WIDE  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             load_now,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp,
   input logic             periodic,
   input logic             mflag,
   input logic             oflag,
   input logic             ctrl_wr,
   input logic             irq
);
   a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_now && count == cmp) |=> mflag);

   a_r4_periodic_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_now && count == cmp && periodic) |=> (count == '0));

   a_r5_free_run_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_now && count == cmp && !periodic && count != '1)
      |=> (count == CNT_W'($past(count) + 1'b1)));

   a_r6_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE && tick && !load_now && count == '1 && count != cmp) |=> oflag);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mflag && !ctrl_wr) |=> mflag);

   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mflag);

   a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_now) |=> (count == $past(count)));
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W), .WIDE(WIDE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .tick     (cnt_tick),
   .load_now (load_now),
   .count    (count_q),
   .cmp      (cmp_q),
   .periodic (periodic),
   .mflag    (match_flag),
   .oflag    (ovf_flag),
   .ctrl_wr  (ctrl_wr),
   .irq      (irq)
);

// File: tb/sim_cmt_channel.sv
`timescale 1ns/1ps
module sim_cmt_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        run = 1'b0;
   logic [1:0]  a_addr = '0, b_addr = '0;
   logic        a_we = 1'b0, b_we = 1'b0;
   logic [31:0] a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cmt_channel #(.CNT_W(32), .WIDE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run),
      .addr(a_addr), .wr_en(a_we), .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq));

   cmt_channel #(.CNT_W(16), .WIDE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run),
      .addr(b_addr), .wr_en(b_we), .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      if (sel) begin b_addr = a; b_wdata = d; b_we = 1'b1; end
      else     begin a_addr = a; a_wdata = d; a_we = 1'b1; end
      @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
   endtask

   task automatic rchk(input bit sel, input logic [1:0] a, input logic [31:0] exp,
                       input string tag);
      if (sel) b_addr = a; else a_addr = a;
      #1;
      chk(tag, sel ? b_rdata : a_rdata, exp);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      rchk(0, 2'd0, 32'h0, "R1 ctrl after reset");
      rchk(0, 2'd1, 32'h0, "R1 count after reset");
      rchk(0, 2'd2, 32'hFFFF_FFFF, "R1 compare after reset");
      chk("R1 irq after reset", {31'b0, a_irq}, 32'h0);
   endtask

   task automatic t_div_one;
      wr(0, 2'd0, 32'h0000_0007);
      run = 1'b1;
      pulses(5);
      rchk(0, 2'd1, 32'd5, "R2 code 7 one strobe per count");
   endtask

   task automatic t_load_sync;
      wr(0, 2'd1, 32'h0);
      pulses(1);
      rchk(0, 2'd1, 32'd6, "R9 old count before second strobe");
      pulses(1);
      rchk(0, 2'd1, 32'd0, "R9 written value at second strobe");
   endtask

   task automatic t_div_codes;
      wr(0, 2'd0, 32'h0000_0004);
      pulses(7);   rchk(0, 2'd1, 32'd0, "R2 code 4 before eighth strobe");
      pulses(1);   rchk(0, 2'd1, 32'd1, "R2 code 4 at eighth strobe");
      wr(0, 2'd0, 32'h0000_0005);
      pulses(31);  rchk(0, 2'd1, 32'd1, "R2 code 5 before 32nd strobe");
      pulses(1);   rchk(0, 2'd1, 32'd2, "R2 code 5 at 32nd strobe");
      wr(0, 2'd0, 32'h0000_0006);
      pulses(127); rchk(0, 2'd1, 32'd2, "R2 code 6 before 128th strobe");
      pulses(1);   rchk(0, 2'd1, 32'd3, "R2 code 6 at 128th strobe");
      wr(0, 2'd0, 32'h0000_0000);
      pulses(20);  rchk(0, 2'd1, 32'd3, "R2 reserved code holds count");
   endtask

   task automatic t_periodic;
      run = 1'b0;
      wr(0, 2'd0, 32'h0000_0107);
      wr(0, 2'd2, 32'd3);
      rchk(0, 2'd2, 32'd3, "R11 compare reads back");
      wr(0, 2'd1, 32'd0);
      pulses(2);
      run = 1'b1;
      pulses(3);
      rchk(0, 2'd1, 32'd3, "R4 count reaches compare");
      rchk(0, 2'd0, 32'h0000_0107, "R4 no flag before match tick");
      pulses(1);
      rchk(0, 2'd1, 32'd0, "R4 periodic restart");
      rchk(0, 2'd0, 32'h0000_8107, "R4 match flag set");
      pulses(3);   rchk(0, 2'd1, 32'd3, "R4 second period mid");
      pulses(1);   rchk(0, 2'd1, 32'd0, "R4 period is compare+1");
   endtask

   task automatic t_irq_route;
      chk("R8 irq low with enable clear", {31'b0, a_irq}, 32'h0);
      wr(0, 2'd0, 32'h0000_81A7);
      rchk(0, 2'd0, 32'h0000_81A7, "R7 writing 1 keeps flag");
      chk("R8 irq with route 2", {31'b0, a_irq}, 32'h1);
      wr(0, 2'd0, 32'h0000_8197);
      chk("R8 irq low with route 1", {31'b0, a_irq}, 32'h0);
      wr(0, 2'd0, 32'h0000_8187);
      chk("R8 irq low with route 0", {31'b0, a_irq}, 32'h0);
      wr(0, 2'd0, 32'h0000_81A7);
      chk("R8 irq back with route 2", {31'b0, a_irq}, 32'h1);
      wr(0, 2'd0, 32'h0000_01A7);
      rchk(0, 2'd0, 32'h0000_01A7, "R7 writing 0 clears flag");
      chk("R7 irq drops after clear", {31'b0, a_irq}, 32'h0);
   endtask

   task automatic t_set_wins;
      pulses(3);
      rchk(0, 2'd1, 32'd3, "R7 count at compare before race");
      @(negedge clk);
      a_addr = 2'd0; a_wdata = 32'h0000_01A7; a_we = 1'b1; ref_tick = 1'b1;
      @(negedge clk);
      a_we = 1'b0; ref_tick = 1'b0;
      rchk(0, 2'd0, 32'h0000_81A7, "R7 match beats clearing write");
      rchk(0, 2'd1, 32'd0, "R4 restart during race");
   endtask

   task automatic t_free_run;
      run = 1'b0;
      wr(0, 2'd0, 32'h0000_0007);
      wr(0, 2'd2, 32'd2);
      wr(0, 2'd1, 32'd0);
      pulses(2);
      run = 1'b1;
      pulses(3);
      rchk(0, 2'd1, 32'd3, "R5 counts past compare");
      rchk(0, 2'd0, 32'h0000_8007, "R5 flag set without restart");
   endtask

   task automatic t_overflow;
      run = 1'b0;
      wr(0, 2'd0, 32'h0000_0007);
      wr(0, 2'd2, 32'd5);
      wr(0, 2'd1, 32'hFFFF_FFFE);
      pulses(2);
      run = 1'b1;
      pulses(1);
      rchk(0, 2'd1, 32'hFFFF_FFFF, "R6 count at all-ones");
      rchk(0, 2'd0, 32'h0000_0007, "R6 no flag before wrap");
      pulses(1);
      rchk(0, 2'd1, 32'h0, "R6 wrapped to zero");
      rchk(0, 2'd0, 32'h0000_4007, "R6 overflow flag set");
      wr(0, 2'd0, 32'h0000_0007);
      rchk(0, 2'd0, 32'h0000_0007, "R7 overflow cleared by 0");
      run = 1'b0;
      wr(0, 2'd2, 32'hFFFF_FFFF);
      wr(0, 2'd1, 32'hFFFF_FFFF);
      pulses(2);
      run = 1'b1;
      pulses(1);
      rchk(0, 2'd0, 32'h0000_8007, "R6 wrap at compare is match only");
   endtask

   task automatic t_run_gate;
      run = 1'b0;
      wr(0, 2'd0, 32'h0000_0004);
      wr(0, 2'd1, 32'd0);
      pulses(2);
      run = 1'b1;
      pulses(5);
      run = 1'b0;
      pulses(10);
      rchk(0, 2'd1, 32'd0, "R10 held while stopped");
      run = 1'b1;
      pulses(7);
      rchk(0, 2'd1, 32'd0, "R10 divider restarted from zero");
      pulses(1);
      rchk(0, 2'd1, 32'd1, "R10 resumes after full interval");
      run = 1'b0;
      pulses(16);
      rchk(0, 2'd1, 32'd1, "R10 nonzero count held");
   endtask

   task automatic t_narrow;
      run = 1'b0;
      wr(1, 2'd0, 32'h0000_00C0);
      rchk(1, 2'd0, 32'h0000_0040, "R3 narrow enable, flag not set by write");
      wr(1, 2'd2, 32'd1);
      wr(1, 2'd1, 32'd0);
      pulses(2);
      run = 1'b1;
      pulses(8);
      rchk(1, 2'd1, 32'd1, "R3 narrow code 0 eight strobes");
      chk("R3 narrow irq low before match", {31'b0, b_irq}, 32'h0);
      pulses(8);
      rchk(1, 2'd1, 32'd0, "R3 narrow always periodic");
      rchk(1, 2'd0, 32'h0000_00C0, "R3 narrow match flag bit 7");
      chk("R8 narrow irq", {31'b0, b_irq}, 32'h1);
      run = 1'b0;
      wr(1, 2'd0, 32'h0000_4043);
      rchk(1, 2'd0, 32'h0000_0043, "R3 bit 14 not stored");
      chk("R7 narrow irq cleared", {31'b0, b_irq}, 32'h0);
      wr(1, 2'd1, 32'd0);
      pulses(2);
      run = 1'b1;
      pulses(511);
      rchk(1, 2'd1, 32'd0, "R3 code 3 before 512th strobe");
      pulses(1);
      rchk(1, 2'd1, 32'd1, "R3 code 3 at 512th strobe");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div_one();
      t_load_sync();
      t_div_codes();
      t_periodic();
      t_irq_route();
      t_set_wins();
      t_free_run();
      t_overflow();
      t_run_gate();
      t_narrow();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule